// File: doc/BRIEF.md
# TLB Management Register Port

This block is the software-visible register front end of a software-managed translation buffer. A processor core reaches six registers over a simple request bus that carries a register number, a write strobe, an upper-word qualifier and 32 bits of data. The registers are a process identifier, a zone-protection word, an entry index, a search trigger, and two windows onto the buffer entry that the index currently selects. The entry storage and the address-match logic sit outside the block. The block drives the storage read/write strobes and the entry index, and it runs a request/response exchange with the lookup logic.

Each buffer entry carries an 8-bit owner identifier, and the block keeps these identifiers in its own small store. Writing the tag window records the current process identifier as the entry's owner. Reading the tag window copies the owner back into the process identifier. A write to the search register hands a page number to the lookup logic. The result is posted into the index register: a hit loads the matched index, and a miss raises a sticky flag in bit 31.

Two configuration inputs limit what software may do. One says whether translation hardware is present. The other is a 2-bit access level that gates reads and writes separately.

Top module: `mmu_sreg_port`

## Requirements
- R1: Register numbers are 0 process ID, 1 zone protection, 2 index, 3 entry data window, 4 entry tag window, 5 search; 6 and 7 are undefined. Every storage access through register 3 or 4 uses the low 8 bits of the index register as the entry number.
- R2: A write to register 4 sends the data to the storage as the tag word, and in the same cycle stores bits [7:0] of the process ID as that entry's owner ID.
- R3: A read of register 4 returns the entry's tag word and loads the process ID register with the entry's owner ID, zero-extended.
- R4: A write to register 2 changes bits [30:0] only; bit 31 keeps its value.
- R5: A write to register 5 at access level 2 or 3 starts a lookup of the written value ANDed with 0xFFFFFC00, tagged with the current privilege. A hit loads the whole index register with the matched index; a miss sets bit 31 and leaves bits [30:0] alone. The index register changes on the clock edge after the edge that samples the lookup response.
- R6: A read of register 5, 6 or 7 returns 0 and changes no register.
- R7: The upper-word qualifier is honoured only for register 3, where it selects bits [63:32] of the data word. With the qualifier set, any other register number is ignored and reads 0.
- R8: Writes to registers 0, 1 and 5 take effect only at access level 2 or 3. Reads of registers 0, 1, 3 and 4 return data only when bit 0 of the access level is 1 and return 0 otherwise. Index reads and writes, and writes to registers 3 and 4, need only a nonzero level.
- R9: With the hardware marked absent, or with access level 0, every request is ignored and every read returns 0.
- R10: Reset clears the process ID, zone, index and owner IDs to 0.
- R11: Every accepted read raises the read-valid output, with its data, on the clock edge that samples the request.
- R12: Requests that arrive while a search is outstanding are ignored and produce no read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_present | input | 1 | Translation hardware is present |
| cfg_level | input | 2 | Register access level |
| priv_user | input | 1 | Current privilege is user mode |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_ext | input | 1 | Upper-word qualifier |
| req_regnum | input | 3 | Register number |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| tlb_idx | output | 8 | Entry number for storage access |
| tlb_rd_en | output | 1 | Storage read this cycle |
| tlb_wr_en | output | 1 | Storage write this cycle |
| tlb_hi | output | 1 | Storage access targets the tag word |
| tlb_ext | output | 1 | Storage access targets data bits [63:32] |
| tlb_wdata | output | 32 | Storage write data |
| tlb_rdata | input | 32 | Storage read data, combinational on the selects |
| lkp_req | output | 1 | Lookup outstanding |
| lkp_vpn | output | 32 | Masked page number to look up |
| lkp_user | output | 1 | Privilege of the lookup |
| lkp_valid | input | 1 | Lookup response valid |
| lkp_hit | input | 1 | Lookup matched an entry |
| lkp_idx | input | 8 | Matched entry index |

## Verification
Storage strobes and the owner-ID update happen in the cycle of the request. Read data and read-valid are due on the edge that samples the request, so the bench checks them at the following falling edge. The index register changes two edges after a lookup response is first sampled. Every bench operation therefore waits several idle cycles before the next request, and the checker watches that two-edge window directly. The bench sweeps all combinations of presence, access level, qualifier, register number and direction against its own register and storage model.

// File: rtl/mmu_sreg_pkg.sv
// Shared types for the TLB management register port.
// Assumes a 32-bit register bus and 3-bit register numbers.
package mmu_sreg_pkg;

    localparam int          DATA_W        = 32;
    localparam int          OWNER_W       = 8;
    localparam logic [31:0] PAGE_NUM_MASK = 32'hFFFF_FC00;

    typedef enum logic [2:0] {
        RN_PROC_ID  = 3'd0,
        RN_ZONE     = 3'd1,
        RN_INDEX    = 3'd2,
        RN_ENTRY_LO = 3'd3,
        RN_ENTRY_HI = 3'd4,
        RN_SEARCH   = 3'd5
    } regnum_e;

    typedef enum logic [2:0] {
        SRC_ZERO, SRC_PID, SRC_ZONE, SRC_INDEX, SRC_ENTRY
    } rsrc_e;

    typedef enum logic [1:0] {
        SR_IDLE, SR_WAIT, SR_POST
    } search_st_e;

    typedef struct packed {
        logic  rd_en;
        rsrc_e src;
        logic  pid_from_owner;
        logic  ent_rd;
        logic  ent_wr;
        logic  ent_hi;
        logic  pid_wr;
        logic  zone_wr;
        logic  idx_wr;
        logic  search;
    } acc_t;

endpackage

// File: rtl/mmu_sreg_decode.sv
// Access decoder: turns one bus request and the configuration into
// per-register actions. Assumes req_valid is already masked while a
// search is outstanding. Purely combinational.
module mmu_sreg_decode
    import mmu_sreg_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_ext,
    input  logic [2:0] req_regnum,
    input  logic       cfg_present,
    input  logic [1:0] cfg_level,
    output acc_t       acc
);

    logic live;
    logic legal;
    logic may_read;
    logic may_wr_priv;

    assign live        = req_valid && cfg_present && (cfg_level != 2'd0);
    assign legal       = !req_ext || (req_regnum == RN_ENTRY_LO);
    assign may_read    = cfg_level[0];
    assign may_wr_priv = cfg_level[1];

    // Map the request onto one action; anything not matched stays idle.
    always_comb begin
        acc       = '0;
        acc.src   = SRC_ZERO;
        acc.rd_en = req_valid && !req_write;
        if (live && legal) begin
            case (regnum_e'(req_regnum))
                RN_PROC_ID: begin
                    if (req_write) acc.pid_wr = may_wr_priv;
                    else if (may_read) acc.src = SRC_PID;
                end
                RN_ZONE: begin
                    if (req_write) acc.zone_wr = may_wr_priv;
                    else if (may_read) acc.src = SRC_ZONE;
                end
                RN_INDEX: begin
                    if (req_write) acc.idx_wr = 1'b1;
                    else acc.src = SRC_INDEX;
                end
                RN_ENTRY_LO, RN_ENTRY_HI: begin
                    acc.ent_hi = (req_regnum == RN_ENTRY_HI);
                    if (req_write) begin
                        acc.ent_wr = 1'b1;
                    end else if (may_read) begin
                        acc.ent_rd         = 1'b1;
                        acc.src            = SRC_ENTRY;
                        acc.pid_from_owner = (req_regnum == RN_ENTRY_HI);
                    end
                end
                RN_SEARCH: begin
                    if (req_write) acc.search = may_wr_priv;
                end
                default: acc.src = SRC_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/mmu_sreg_owner_store.sv
// Per-entry owner-ID store: one OWNER_W-bit ID for each buffer entry.
// Asynchronous read, synchronous write, synchronous active-low reset.
module mmu_sreg_owner_store
    import mmu_sreg_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wr_en,
    input  logic [OWNER_W-1:0] wr_owner,
    output logic [OWNER_W-1:0] rd_owner
);

    logic [OWNER_W-1:0] owner_q [ENTRIES];

    // Clear all IDs on reset, else record the writer's ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) owner_q[i] <= '0;
        end else if (wr_en) begin
            owner_q[idx] <= wr_owner;
        end
    end

    assign rd_owner = owner_q[idx];

endmodule

// File: rtl/mmu_sreg_search.sv
// Search sequencer: captures a masked page number, holds lkp_req until
// the lookup answers, then posts the result for one cycle.
// Assumes lkp_valid is meaningful only while lkp_req is high.
module mmu_sreg_search
    import mmu_sreg_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      start_val,
    input  logic             start_user,
    output logic             lkp_req,
    output logic [31:0]      lkp_vpn,
    output logic             lkp_user,
    input  logic             lkp_valid,
    input  logic             lkp_hit,
    input  logic [IDX_W-1:0] lkp_idx,
    output logic             busy,
    output logic             post_en,
    output logic             post_hit,
    output logic [IDX_W-1:0] post_idx
);

    search_st_e state_q;

    // Step idle -> wait for response -> post result -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SR_IDLE;
            lkp_vpn  <= '0;
            lkp_user <= 1'b0;
            post_hit <= 1'b0;
            post_idx <= '0;
        end else begin
            case (state_q)
                SR_IDLE: if (start) begin
                    lkp_vpn  <= start_val & PAGE_NUM_MASK;
                    lkp_user <= start_user;
                    state_q  <= SR_WAIT;
                end
                SR_WAIT: if (lkp_valid) begin
                    post_hit <= lkp_hit;
                    post_idx <= lkp_idx;
                    state_q  <= SR_POST;
                end
                default: state_q <= SR_IDLE;
            endcase
        end
    end

    assign lkp_req = (state_q == SR_WAIT);
    assign post_en = (state_q == SR_POST);
    assign busy    = (state_q != SR_IDLE);

endmodule

// File: rtl/mmu_sreg_port.sv
// TLB management register port, top level. Holds the process ID, zone
// and index registers, drives entry storage and the lookup exchange,
// and answers reads one edge after the request. Assumes tlb_rdata is
// a combinational function of tlb_idx, tlb_hi and tlb_ext.
module mmu_sreg_port
    import mmu_sreg_pkg::*;
#(
    parameter int TLB_ENTRIES = 256,
    localparam int IDX_W      = $clog2(TLB_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_present,
    input  logic [1:0]       cfg_level,
    input  logic             priv_user,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_ext,
    input  logic [2:0]       req_regnum,
    input  logic [31:0]      req_wdata,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic [IDX_W-1:0] tlb_idx,
    output logic             tlb_rd_en,
    output logic             tlb_wr_en,
    output logic             tlb_hi,
    output logic             tlb_ext,
    output logic [31:0]      tlb_wdata,
    input  logic [31:0]      tlb_rdata,
    output logic             lkp_req,
    output logic [31:0]      lkp_vpn,
    output logic             lkp_user,
    input  logic             lkp_valid,
    input  logic             lkp_hit,
    input  logic [IDX_W-1:0] lkp_idx
);

    logic [31:0]        pid_q;
    logic [31:0]        zpr_q;
    logic [31:0]        idx_q;
    logic               busy;
    logic               post_en;
    logic               post_hit;
    logic [IDX_W-1:0]   post_idx;
    logic [OWNER_W-1:0] owner_rd;
    logic [31:0]        rd_mux;
    acc_t               acc;

    mmu_sreg_decode u_decode (
        .req_valid  (req_valid && !busy),
        .req_write  (req_write),
        .req_ext    (req_ext),
        .req_regnum (req_regnum),
        .cfg_present(cfg_present),
        .cfg_level  (cfg_level),
        .acc        (acc)
    );

    mmu_sreg_owner_store #(.ENTRIES(TLB_ENTRIES)) u_owner (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx_q[IDX_W-1:0]),
        .wr_en   (acc.ent_wr && acc.ent_hi),
        .wr_owner(pid_q[OWNER_W-1:0]),
        .rd_owner(owner_rd)
    );

    mmu_sreg_search #(.IDX_W(IDX_W)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (acc.search),
        .start_val (req_wdata),
        .start_user(priv_user),
        .lkp_req   (lkp_req),
        .lkp_vpn   (lkp_vpn),
        .lkp_user  (lkp_user),
        .lkp_valid (lkp_valid),
        .lkp_hit   (lkp_hit),
        .lkp_idx   (lkp_idx),
        .busy      (busy),
        .post_en   (post_en),
        .post_hit  (post_hit),
        .post_idx  (post_idx)
    );

    assign tlb_idx   = idx_q[IDX_W-1:0];
    assign tlb_rd_en = acc.ent_rd;
    assign tlb_wr_en = acc.ent_wr;
    assign tlb_hi    = acc.ent_hi;
    assign tlb_ext   = req_ext;
    assign tlb_wdata = req_wdata;

    // Select the read source named by the decoder.
    always_comb begin
        case (acc.src)
            SRC_PID:   rd_mux = pid_q;
            SRC_ZONE:  rd_mux = zpr_q;
            SRC_INDEX: rd_mux = idx_q;
            SRC_ENTRY: rd_mux = tlb_rdata;
            default:   rd_mux = '0;
        endcase
    end

    // Process ID: software write, or owner copy on a tag-window read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pid_q <= '0;
        else if (acc.pid_wr)         pid_q <= req_wdata;
        else if (acc.pid_from_owner) pid_q <= 32'(owner_rd);
    end

    // Zone protection word: plain software register.
    always_ff @(posedge clk) begin
        if (!rst_n)           zpr_q <= '0;
        else if (acc.zone_wr) zpr_q <= req_wdata;
    end

    // Index: search result has priority; software writes skip bit 31.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (post_en) begin
            if (post_hit) idx_q     <= 32'(post_idx);
            else          idx_q[31] <= 1'b1;
        end else if (acc.idx_wr) begin
            idx_q[30:0] <= req_wdata[30:0];
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc.rd_en;
            rd_data  <= acc.rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/mmu_sreg_port_chk.sv
// Property checker for mmu_sreg_port, attached with bind below.
module mmu_sreg_port_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_present,
    input logic [1:0]       cfg_level,
    input logic             req_valid,
    input logic             req_write,
    input logic [2:0]       req_regnum,
    input logic             rd_valid,
    input logic [31:0]      rd_data,
    input logic [IDX_W-1:0] tlb_idx,
    input logic             tlb_rd_en,
    input logic             tlb_wr_en,
    input logic             tlb_hi,
    input logic             tlb_ext,
    input logic             lkp_req,
    input logic [31:0]      lkp_vpn,
    input logic             lkp_valid,
    input logic             lkp_hit,
    input logic [IDX_W-1:0] lkp_idx,
    input logic [31:0]      pid_q,
    input logic [31:0]      zpr_q,
    input logic [31:0]      idx_q,
    input logic             busy
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pid_q == 0 && zpr_q == 0 && idx_q == 0)); // R10
    AST_ENTRY_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_rd_en || tlb_wr_en) |-> tlb_idx == idx_q[IDX_W-1:0]); // R1
    AST_INDEX_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_regnum == 3'd2 && !busy) |=> idx_q[31] == $past(idx_q[31])); // R4
    AST_VPN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req |-> lkp_vpn[9:0] == 10'd0); // R5
    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && lkp_valid && !lkp_hit) |-> ##2 idx_q[31]); // R5
    AST_HIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && lkp_valid && lkp_hit) |-> ##2 (idx_q == 32'($past(lkp_idx, 2)))); // R5
    AST_EXT_ONLY_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ((tlb_rd_en || tlb_wr_en) && tlb_ext) |-> !tlb_hi); // R7
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_present || cfg_level == 2'd0) |-> (!tlb_rd_en && !tlb_wr_en)); // R9
    AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(!cfg_present || cfg_level == 2'd0)) |-> rd_data == 32'd0); // R9
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !busy) |=> rd_valid); // R11
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!tlb_rd_en && !tlb_wr_en)); // R12

endmodule

bind mmu_sreg_port mmu_sreg_port_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/mmu_sreg_port_bench.sv
module mmu_sreg_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LKP_LAT    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_present = 1'b1;
    logic [1:0]  cfg_level = 2'd3;
    logic        priv_user = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ext = 1'b0;
    logic [2:0]  req_regnum = 3'd0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [7:0]  tlb_idx;
    logic        tlb_rd_en, tlb_wr_en, tlb_hi, tlb_ext;
    logic [31:0] tlb_wdata;
    logic [31:0] tlb_rdata;
    logic        lkp_req;
    logic [31:0] lkp_vpn;
    logic        lkp_user;
    logic        lkp_valid = 1'b0;
    logic        lkp_hit = 1'b0;
    logic [7:0]  lkp_idx = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mmu_sreg_port u_mmu_sreg_port (.*);

    // Device-side entry storage seen by the block.
    logic [63:0] dev_lo [256];
    logic [31:0] dev_hi [256];
    initial for (int i = 0; i < 256; i++) begin dev_lo[i] = '0; dev_hi[i] = '0; end
    always @(posedge clk) if (tlb_wr_en) begin
        if (tlb_hi)       dev_hi[tlb_idx]        <= tlb_wdata;
        else if (tlb_ext) dev_lo[tlb_idx][63:32] <= tlb_wdata;
        else              dev_lo[tlb_idx][31:0]  <= tlb_wdata;
    end
    assign tlb_rdata = tlb_hi ? dev_hi[tlb_idx] : (tlb_ext ? dev_lo[tlb_idx][63:32] : dev_lo[tlb_idx][31:0]);

    // Expected model, built from the requirements.
    logic [31:0] m_pid = '0, m_zpr = '0, m_idx = '0;
    logic [7:0]  m_own [256];
    logic [63:0] e_lo [256];
    logic [31:0] e_hi [256];
    initial for (int i = 0; i < 256; i++) begin m_own[i] = '0; e_lo[i] = '0; e_hi[i] = '0; end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Lookup responder: hit = vpn[12], index = vpn[20:13].
    initial forever begin
        @(posedge clk);
        if (lkp_req) begin
            check("R5 vpn mask", 32'(lkp_vpn[9:0]), 32'd0);
            check("R5 privilege", 32'(lkp_user), 32'(priv_user));
            repeat (LKP_LAT) @(negedge clk);
            lkp_valid = 1'b1;
            lkp_hit   = lkp_vpn[12];
            lkp_idx   = lkp_vpn[20:13];
            @(negedge clk);
            lkp_valid = 1'b0;
        end
    end

    function automatic string tag_of(logic live, logic ext, logic [2:0] rn);
        if (!live)             return "R9";
        if (ext && rn != 3'd3) return "R7";
        case (rn)
            3'd2:    return "R4";
            3'd3:    return "R1";
            3'd4:    return "R3";
            3'd5, 3'd6, 3'd7: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Model the effect of one request; returns the expected read data.
    function automatic logic [31:0] model(logic wr, logic ext, logic [2:0] rn, logic [31:0] d);
        logic        live = cfg_present && cfg_level != 2'd0;
        logic [7:0]  ix   = m_idx[7:0];
        logic [31:0] exp  = '0;
        logic [31:0] v;
        if (live && (!ext || rn == 3'd3)) begin
            case (rn)
                3'd0: if (wr) begin if (cfg_level[1]) m_pid = d; end
                      else if (cfg_level[0]) exp = m_pid;
                3'd1: if (wr) begin if (cfg_level[1]) m_zpr = d; end
                      else if (cfg_level[0]) exp = m_zpr;
                3'd2: if (wr) m_idx = {m_idx[31], d[30:0]}; else exp = m_idx;
                3'd3: if (wr) begin
                          if (ext) e_lo[ix][63:32] = d; else e_lo[ix][31:0] = d;
                      end else if (cfg_level[0]) exp = ext ? e_lo[ix][63:32] : e_lo[ix][31:0];
                3'd4: if (wr) begin e_hi[ix] = d; m_own[ix] = m_pid[7:0]; end
                      else if (cfg_level[0]) begin exp = e_hi[ix]; m_pid = 32'(m_own[ix]); end
                3'd5: if (wr && cfg_level[1]) begin
                          v = d & 32'hFFFF_FC00;
                          if (v[12]) m_idx = 32'(v[20:13]); else m_idx[31] = 1'b1;
                      end
                default: exp = '0;
            endcase
        end
        return exp;
    endfunction

    task automatic op(logic wr, logic ext, logic [2:0] rn, logic [31:0] d, string tag);
        logic [31:0] exp = model(wr, ext, rn, d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_ext = ext; req_regnum = rn; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 read valid", 32'(rd_valid), 32'(!wr));
        if (!wr) check(tag, rd_data, exp);
        repeat (8) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        op(1'b0, 1'b0, 3'd0, 0, "R10");
        op(1'b0, 1'b0, 3'd1, 0, "R10");
        op(1'b0, 1'b0, 3'd2, 0, "R10");
        // R2 owner capture through the tag window
        op(1'b1, 1'b0, 3'd2, 32'h0000_0011, "R1");
        op(1'b1, 1'b0, 3'd0, 32'h1234_56AB, "R2");
        op(1'b1, 1'b0, 3'd4, 32'hCAFE_0400, "R2");
        op(1'b1, 1'b0, 3'd0, 32'h0, "R2");
        op(1'b0, 1'b0, 3'd4, 0, "R3");
        op(1'b0, 1'b0, 3'd0, 0, "R2 owner copied");
        // R5 miss then hit, R4 bit 31 kept
        op(1'b1, 1'b0, 3'd2, 32'h0000_0055, "R4");
        op(1'b1, 1'b0, 3'd5, 32'h0000_0FFF, "R5");
        op(1'b0, 1'b0, 3'd2, 0, "R5 miss");
        op(1'b1, 1'b0, 3'd2, 32'h7FFF_FF01, "R4");
        op(1'b0, 1'b0, 3'd2, 0, "R4 bit31 kept");
        priv_user = 1'b1;
        op(1'b1, 1'b0, 3'd5, (32'h5A << 13) | 32'h1000 | 32'h3FF, "R5");
        op(1'b0, 1'b0, 3'd2, 0, "R5 hit");
        priv_user = 1'b0;
        // R12 requests while a search is outstanding are dropped
        void'(model(1'b1, 1'b0, 3'd5, 32'h0));
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_regnum = 3'd5; req_wdata = 32'h0;
        @(negedge clk);
        req_regnum = 3'd0; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 no read valid", 32'(rd_valid), 32'd0);
        repeat (8) @(negedge clk);
        op(1'b0, 1'b0, 3'd0, 0, "R12 pid unchanged");
        // Sweep of presence, level, qualifier, register and direction
        seed = 32'h1357_9BDF;
        for (int p = 0; p < 2; p++)
            for (int lv = 0; lv < 4; lv++)
                for (int e = 0; e < 2; e++)
                    for (int rn = 0; rn < 8; rn++) begin
                        cfg_present = p[0]; cfg_level = lv[1:0];
                        seed = seed * 32'h9E37_79B1 + 32'd7;
                        op(1'b1, e[0], rn[2:0], seed, tag_of(p[0] && lv != 0, e[0], rn[2:0]));
                        op(1'b0, e[0], rn[2:0], 0, tag_of(p[0] && lv != 0, e[0], rn[2:0]));
                        cfg_present = 1'b1; cfg_level = 2'd3;
                        op(1'b0, 1'b0, 3'd2, 0, "R4 sweep index");
                        op(1'b0, 1'b0, 3'd0, 0, "R8 sweep pid");
                    end
        disable watchdog;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule